// File: doc/BRIEF.md
# Dynamic Bus Width Adapter

This block takes one 32-bit access from inside the chip (a word address, a four-bit byte mask and, for writes, a data word) and carries it out over an external data bus. The external bus may be 32, 16 or 8 bits wide, and that width may differ from one bus cycle to the next. The adapter drives the access as an external cycle and asks the external logic which width applies. It learns the width from two active-low size inputs, sampled on the clock edge that ends each data cycle. When that edge leaves bytes still untransferred, the adapter starts another cycle that enables only those bytes.

For writes, the adapter copies the upper-half bytes down onto the low lanes, so that a narrow device wired to the low lanes finds its byte there. For reads, it places each returned byte in its correct position in a 32-bit holding register. It reports completion with a one-cycle done pulse, after the last enabled byte has crossed the bus. A request with an empty byte mask starts no bus cycle and completes at once.

Top module: `bus_width_adapter`

## Requirements
- R1: After reset, req_ready is 1, bus_active is 0, bus_be_n is 4'hF and done is 0.
- R2: When bus_rdy_n is low on a rising edge, the size inputs are sampled on that edge. bus_sz8_n low selects an 8-bit bus whether or not bus_sz16_n is low. bus_sz16_n low with bus_sz8_n high selects 16 bits. Both high selects 32 bits.
- R3: With a fixed width and a non-empty mask, the access takes a set number of data cycles. At 32 bits it takes 1. At 16 bits it takes one cycle for each half (bytes 1:0, bytes 3:2) that has an enabled byte. At 8 bits it takes one cycle for each enabled byte.
- R4: bus_be_n is active low, and bit i enables lane i, which carries byte i. In every cycle it enables exactly the bytes not yet transferred. A 16-bit cycle moves the low half first if that half has any enabled byte. An 8-bit cycle moves the lowest-numbered pending byte.
- R5: During a write, bus_dout[31:16] carries data bytes 3:2. bus_dout[15:8] carries byte 1 while byte 0 or byte 1 is pending, and byte 3 otherwise. bus_dout[7:0] carries the lowest-numbered pending byte.
- R6: On a read, a byte returned at 32 bits comes from lane i. A byte returned at 16 bits comes from lane (i mod 2). A byte returned at 8 bits comes from lane 0. When done is high, rdata holds every enabled byte in its place and zero in every byte that was not enabled.
- R7: A width change between the cycles of one access is honoured. Every enabled byte is still moved exactly once, to the correct place.
- R8: A request with req_mask equal to 0 starts no bus cycle, and done is high in the next cycle.
- R9: bus_addr and bus_write hold the request's values, unchanged, for the whole access.
- R10: done is high for exactly one cycle, in the cycle after the edge that ends the last data cycle. In that cycle bus_active is low and req_ready is high.
- R11: While bus_rdy_n is high, the cycle is extended and the size inputs are ignored. bus_be_n, bus_dout and bus_addr hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present; accepted while req_ready is high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_mask | input | 4 | Active-high byte mask, bit i = byte i |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Adapter idle |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Assembled read word |
| bus_active | output | 1 | External cycle in progress |
| bus_write | output | 1 | Direction of the external cycle |
| bus_addr | output | AW | External word address |
| bus_be_n | output | 4 | Active-low byte enables |
| bus_dout | output | 32 | Write data on the external lanes |
| bus_din | input | 32 | Read data from the external lanes |
| bus_rdy_n | input | 1 | Active-low end of data cycle |
| bus_sz16_n | input | 1 | Active-low 16-bit width report |
| bus_sz8_n | input | 1 | Active-low 8-bit width report |

## Verification
Every one of the 16 byte masks is tried, in both directions, under a fixed 32-, 16- and 8-bit width. These fixed-width runs show whether the number of cycles and the lane choice follow the width: they tell a mask that spans both halves apart from one confined to a single half, and masks with gaps apart from contiguous ones. A fourth sweep changes the reported width on every cycle of the access. It exposes any logic that remembers an earlier width, or that recomputes the enables from the original mask rather than from the bytes still pending. The external model fills unused lanes with a filler pattern and sometimes asserts both size inputs, so a read from the wrong lane or a wrong size priority shows up in the data. Inserted wait states, with bogus size values, check that a cycle is only closed by ready.

// File: rtl/bus_width_adapter.sv
`timescale 1ns/1ps
module bus_width_adapter #(
  parameter int AW = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [3:0]    req_mask,
  input  logic [31:0]   req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [31:0]   rdata,
  output logic          bus_active,
  output logic          bus_write,
  output logic [AW-1:0] bus_addr,
  output logic [3:0]    bus_be_n,
  output logic [31:0]   bus_dout,
  input  logic [31:0]   bus_din,
  input  logic          bus_rdy_n,
  input  logic          bus_sz16_n,
  input  logic          bus_sz8_n
);
  logic          busy, wr_q, done_q;
  logic [AW-1:0] addr_q;
  logic [3:0]    rem;
  logic [31:0]   wd_q, rd_q;
  logic [1:0]    lo_idx;

  wire       narrow8  = !bus_sz8_n;
  wire       narrow16 = !bus_sz16_n && bus_sz8_n;
  wire       lo_pend  = |rem[1:0];
  wire [3:0] lowest   = rem & (~rem + 4'd1);
  wire [3:0] half     = lo_pend ? (rem & 4'b0011) : (rem & 4'b1100);
  wire [3:0] xfer     = narrow8 ? lowest : (narrow16 ? half : rem);
  wire       beat     = busy && !bus_rdy_n;
  wire       last     = (rem & ~xfer) == 4'd0;

  always_comb begin
    if (rem[0])      lo_idx = 2'd0;
    else if (rem[1]) lo_idx = 2'd1;
    else if (rem[2]) lo_idx = 2'd2;
    else             lo_idx = 2'd3;
  end

  assign req_ready  = !busy;
  assign done       = done_q;
  assign rdata      = rd_q;
  assign bus_active = busy;
  assign bus_write  = wr_q;
  assign bus_addr   = addr_q;
  assign bus_be_n   = busy ? ~rem : 4'hF;
  assign bus_dout   = {wd_q[31:16], lo_pend ? wd_q[15:8] : wd_q[31:24], wd_q[8*lo_idx +: 8]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
      addr_q <= '0;
      rem    <= 4'd0;
      wd_q   <= 32'd0;
      rd_q   <= 32'd0;
    end else begin
      done_q <= 1'b0;
      if (!busy && req_valid) begin
        addr_q <= req_addr;
        wr_q   <= req_write;
        wd_q   <= req_wdata;
        rd_q   <= 32'd0;
        rem    <= req_mask;
        busy   <= |req_mask;
        done_q <= ~|req_mask;
      end else if (beat) begin
        rem <= rem & ~xfer;
        if (last) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
        if (!wr_q) begin
          for (int i = 0; i < 4; i++) begin
            if (xfer[i])
              rd_q[8*i +: 8] <= narrow8 ? bus_din[7:0]
                              : (narrow16 ? bus_din[8*(i%2) +: 8] : bus_din[8*i +: 8]);
          end
        end
      end
    end
  end

  a_r8_empty_done: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && req_mask == 4'd0) |=> (done && !bus_active));

  a_r4_be_shrink: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && !bus_rdy_n) |=> (!bus_active ||
      ((((~bus_be_n) & $past(bus_be_n)) == 4'd0) &&
       ($countones(~bus_be_n) < $countones(~$past(bus_be_n))))));

  a_r2_byte_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && !bus_rdy_n && !bus_sz8_n && $countones(~bus_be_n) > 1) |=>
      (bus_active && $countones(~bus_be_n) == $countones(~$past(bus_be_n)) - 1));

  a_r3_full_width: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && !bus_rdy_n && bus_sz8_n && bus_sz16_n) |=> (!bus_active && done));

  a_r11_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && bus_rdy_n) |=> (bus_active && $stable(bus_be_n) &&
      $stable(bus_dout) && $stable(bus_addr)));

  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_active && $past(bus_active)) |-> ($stable(bus_addr) && $stable(bus_write)));

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && !bus_active));

  a_r4_no_empty_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bus_active |-> (bus_be_n != 4'hF));
endmodule

// File: tb/bus_width_adapter_bench.sv
`timescale 1ns/1ps
module bus_width_adapter_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [29:0] req_addr = '0;
  logic [3:0]  req_mask = 4'd0;
  logic [31:0] req_wdata = 32'd0, bus_din = 32'd0;
  logic        bus_rdy_n = 1'b1, bus_sz16_n = 1'b1, bus_sz8_n = 1'b1;
  logic        req_ready, done, bus_active, bus_write;
  logic [31:0] rdata, bus_dout;
  logic [29:0] bus_addr;
  logic [3:0]  bus_be_n;
  int vectors = 0, fails = 0;

  always #2.5 clk = ~clk;

  bus_width_adapter #(.AW(30)) u_bus_width_adapter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_mask(req_mask), .req_wdata(req_wdata),
    .req_ready(req_ready), .done(done), .rdata(rdata), .bus_active(bus_active),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_be_n(bus_be_n),
    .bus_dout(bus_dout), .bus_din(bus_din), .bus_rdy_n(bus_rdy_n),
    .bus_sz16_n(bus_sz16_n), .bus_sz8_n(bus_sz8_n));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int low_byte(input logic [3:0] p);
    if (p[0]) return 0;
    if (p[1]) return 1;
    if (p[2]) return 2;
    return 3;
  endfunction

  function automatic logic [31:0] bytes_of(input logic [3:0] m);
    return {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
  endfunction

  task automatic run(input int mode, input logic [3:0] mask, input bit wr);
    logic [31:0] mem, init, wdata, xw;
    logic [3:0]  pend, xf;
    logic [29:0] addr;
    int cyc, w, guard, k, expc;
    bit waited, lo;
    init  = 32'h8E3D57A1 + 32'h01030507 * mask;
    mem   = init;
    wdata = 32'h6B5A4938 + 32'h11111111 * mask + {31'd0, wr};
    addr  = {mask, 26'h15A5A5 ^ 26'(mode)};
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_mask = mask; req_wdata = wdata; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    pend = mask; cyc = 0; waited = 0; guard = 0;
    while (!done && guard < 40) begin
      guard++;
      bus_rdy_n = 1'b1;
      if (bus_active) begin
        chk(bus_be_n == ~pend, "R4 byte enables", {28'd0, bus_be_n}, {28'd0, ~pend});
        chk(bus_addr == addr && bus_write == wr, "R9 address/direction",
            {1'b0, bus_write, bus_addr}, {1'b0, wr, addr});
        lo = |pend[1:0];
        if (wr) begin
          xw = {wdata[31:16], lo ? wdata[15:8] : wdata[31:24], wdata[8*low_byte(pend) +: 8]};
          chk(bus_dout == xw, "R5 write lanes", bus_dout, xw);
        end
        if (!waited && (mask[1] ^ wr)) begin
          bus_sz8_n = 1'b0; bus_sz16_n = 1'b0; bus_din = 32'hDEADBEEF;
          waited = 1;
        end else begin
          w = (mode < 3) ? mode : (cyc + mask) % 3;
          bus_sz8_n  = (w == 2) ? 1'b0 : 1'b1;
          bus_sz16_n = (w == 1) ? 1'b0 : ((w == 2) ? mask[0] : 1'b1);
          if (w == 0) begin
            xf = pend; bus_din = mem;
            for (int i = 0; i < 4; i++) if (xf[i] && wr) mem[8*i +: 8] = bus_dout[8*i +: 8];
          end else if (w == 1) begin
            xf = lo ? (pend & 4'b0011) : (pend & 4'b1100);
            bus_din = lo ? {16'hEEEE, mem[15:0]} : {16'hEEEE, mem[31:16]};
            for (int i = 0; i < 4; i++) if (xf[i] && wr) mem[8*i +: 8] = bus_dout[8*(i%2) +: 8];
          end else begin
            k = low_byte(pend);
            xf = 4'b0001 << k;
            bus_din = {24'hEEEEEE, mem[8*k +: 8]};
            if (wr) mem[8*k +: 8] = bus_dout[7:0];
          end
          bus_rdy_n = 1'b0;
          pend = pend & ~xf;
          cyc++;
          waited = 0;
        end
      end
      @(negedge clk);
    end
    bus_rdy_n = 1'b1;
    chk(done && !bus_active && req_ready, "R10 done after last cycle",
        {29'd0, done, bus_active, req_ready}, 32'd5);
    if (mask == 4'd0)
      chk(cyc == 0 && guard == 0, "R8 empty mask no cycle", cyc, 0);
    if (mode < 3) begin
      expc = (mode == 0) ? int'(mask != 0)
           : (mode == 1) ? int'(|mask[1:0]) + int'(|mask[3:2]) : $countones(mask);
      chk(cyc == expc, "R3 cycle count", cyc, expc);
    end
    if (wr) begin
      xw = (wdata & bytes_of(mask)) | (init & ~bytes_of(mask));
      chk(mem == xw, mode == 3 ? "R7 mixed width write" : "R5 write result", mem, xw);
    end else begin
      xw = init & bytes_of(mask);
      chk(rdata == xw, mode == 3 ? "R7 mixed width read" : "R6 read assembly", rdata, xw);
    end
    @(negedge clk);
    chk(!done, "R10 single-cycle pulse", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready && !bus_active && bus_be_n == 4'hF && !done, "R1 reset state",
        {26'd0, req_ready, bus_active, bus_be_n}, {26'd0, 1'b1, 1'b0, 4'hF});
    rst_n = 1'b1;
    // R2 priority is exercised in mode 2 whenever bus_sz16_n is also driven low;
    // R11 wait cycles carry bogus size values that must be ignored.
    for (int m = 0; m < 4; m++)
      for (int msk = 0; msk < 16; msk++)
        for (int d = 0; d < 2; d++)
          run(m, 4'(msk), d[0]);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule